// File: doc/BRIEF.md
# Context Swap Sequencer for Exceptions and Timer Interrupts

The block steers the state exchange that happens when the processor must leave its current program. It handles two causes. A program check is raised when a privileged opcode is attempted in user mode. A timer interrupt is raised by the count-down timer. For either cause the sequencer moves four words over the one shared bus, one word per transfer, to and from an asynchronous byte-addressed memory of 16-bit words. It stores the old status word, then the old program counter. It then loads a new status word, then a new program counter, from the next two words of the vector area for that cause.

Every memory step holds its address and strobe until the memory answers with ready. While the swap runs, a busy output stalls instruction fetch. A program check pulse is remembered until it is served. A timer request is accepted only while the instruction-boundary strobe is high and no swap is running.

Top module: `ctx_swap_seq`

## Requirements
- R1: After reset `busy`, `mem_rd`, `mem_wr`, `psw_oe`, `pc_oe`, `psw_ld` and `pc_ld` are 0 and `mem_addr` is 0.
- R2: A program check swap performs four steps in this order: write with `psw_oe` at address 0, write with `pc_oe` at address 2, read with `psw_ld` at address 4, read with `pc_ld` at address 6.
- R3: A timer swap performs the same four steps at addresses 8, 10, 12 and 14.
- R4: While `at_boundary` is low, a high `tmr_req` starts no swap: `busy` and both memory strobes stay 0.
- R5: When a program check and an accepted timer request arrive in the same cycle, the program check swap runs first. A timer request still held at a boundary is taken after it finishes.
- R6: A step whose `mem_rdy` is low keeps `mem_addr`, `mem_rd` and `mem_wr` unchanged in the next cycle.
- R7: `busy` rises in the cycle after a request is accepted. It falls in the cycle after the fourth step sees `mem_rdy`. With memory that is ready in every cycle, `busy` stays high for exactly 4 cycles.
- R8: At most one of `psw_oe`, `pc_oe` and `mem_rd` is high in any cycle, because only that one drives the bus. `mem_rd` and `mem_wr` are never high together.
- R9: A `chk_req` pulse that arrives during a running swap is kept. Its program check swap starts once the running swap ends.
- R10: `psw_ld` and `pc_ld` are high only during a read step in a cycle where `mem_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_req | input | 1 | Program check pulse (privileged opcode in user mode) |
| tmr_req | input | 1 | Timer expiry level |
| at_boundary | input | 1 | High between instructions |
| mem_rdy | input | 1 | Memory finished the current access |
| busy | output | 1 | Swap in progress; stalls fetch |
| mem_addr | output | 16 | Byte address of the current step |
| mem_rd | output | 1 | Memory read strobe; memory drives the bus |
| mem_wr | output | 1 | Memory write strobe |
| psw_oe | output | 1 | Status word drives the bus |
| pc_oe | output | 1 | Program counter drives the bus |
| psw_ld | output | 1 | Status word loads from the bus |
| pc_ld | output | 1 | Program counter loads from the bus |

## Verification
Two things can fall in the same cycle: a program check pulse and a timer request taken at a boundary. The bench raises both on the same clock and keeps the timer request and boundary high. The scoreboard must then see the four low vector steps, followed by the four timer steps. A second case raises a program check pulse in the middle of a timer swap, with memory that waits. The pulse must neither disturb the running steps nor be lost, and its swap must follow directly afterwards.

// File: rtl/ctx_swap_seq.sv
module ctx_swap_seq #(
  parameter int AW = 16,
  parameter logic [AW-1:0] CHK_BASE = 'h0,
  parameter logic [AW-1:0] TMR_BASE = 'h8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_req,
  input  logic          tmr_req,
  input  logic          at_boundary,
  input  logic          mem_rdy,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          psw_oe,
  output logic          pc_oe,
  output logic          psw_ld,
  output logic          pc_ld
);
  localparam int NSTEP = 4;
  localparam int SW = $clog2(NSTEP);

  logic          act, from_tmr, chk_pend;
  logic [SW-1:0] step;

  wire chk_any = chk_req | chk_pend;
  wire start   = !act && (chk_any || (tmr_req && at_boundary));
  wire last    = step == SW'(NSTEP - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      from_tmr <= 1'b0;
      step     <= '0;
      chk_pend <= 1'b0;
    end else begin
      chk_pend <= chk_any & ~(start & chk_any);
      if (start) begin
        act      <= 1'b1;
        from_tmr <= !chk_any;
        step     <= '0;
      end else if (act && mem_rdy) begin
        if (last) act <= 1'b0;
        else      step <= step + 1'b1;
      end
    end
  end

  wire [AW-1:0] base = from_tmr ? TMR_BASE : CHK_BASE;

  assign busy     = act;
  assign mem_addr = act ? base + AW'({step, 1'b0}) : '0;
  assign mem_wr   = act && !step[SW-1];
  assign mem_rd   = act &&  step[SW-1];
  assign psw_oe   = act && step == SW'(0);
  assign pc_oe    = act && step == SW'(1);
  assign psw_ld   = act && step == SW'(2) && mem_rdy;
  assign pc_ld    = act && step == SW'(3) && mem_rdy;
endmodule

module ctx_swap_chk #(parameter int AW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rdy,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          psw_oe,
  input logic          pc_oe,
  input logic          psw_ld,
  input logic          pc_ld
);
  p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({psw_oe, pc_oe, mem_rd}));
  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_hold_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_rdy) |=> ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr)));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr || psw_oe || pc_oe));
  p_load_on_rdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_ld || pc_ld) |-> (mem_rdy && mem_rd));
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_addr[0]);
endmodule

bind ctx_swap_seq ctx_swap_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .busy(busy), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .psw_oe(psw_oe), .pc_oe(pc_oe),
  .psw_ld(psw_ld), .pc_ld(pc_ld)
);

// File: tb/tb_ctx_swap_seq.sv
module tb_ctx_swap_seq;
  logic clk = 0, rst_n = 0;
  logic chk_req = 0, tmr_req = 0, at_boundary = 0, mem_rdy = 0;
  logic busy, mem_rd, mem_wr, psw_oe, pc_oe, psw_ld, pc_ld;
  logic [15:0] mem_addr;

  int total = 0, bad = 0, lat = 0, wcnt = 0;
  bit prev_wait = 0;
  logic [15:0] prev_addr;
  logic prev_rd, prev_wr;
  logic [17:0] q[$];

  always #10 clk = ~clk;

  ctx_swap_seq dut (.clk(clk), .rst_n(rst_n), .chk_req(chk_req), .tmr_req(tmr_req),
    .at_boundary(at_boundary), .mem_rdy(mem_rdy), .busy(busy), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .psw_oe(psw_oe), .pc_oe(pc_oe),
    .psw_ld(psw_ld), .pc_ld(pc_ld));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // item = {kind[1:0], addr}; kind 0 wr psw, 1 wr pc, 2 rd psw, 3 rd pc
  task automatic push_swap(input logic [15:0] base);
    for (int k = 0; k < 4; k++) q.push_back({2'(k), base + 16'(2 * k)});
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (mem_rd || mem_wr) begin
      if (wcnt >= lat) begin mem_rdy = 1; wcnt = 0; end
      else begin mem_rdy = 0; wcnt++; end
    end else begin
      mem_rdy = 0; wcnt = 0;
    end
    #1;
    if (prev_wait)
      chk(mem_addr == prev_addr && mem_rd == prev_rd && mem_wr == prev_wr, "R6",
          int'(mem_addr), int'(prev_addr));
    prev_wait = (mem_rd || mem_wr) && !mem_rdy;
    prev_addr = mem_addr; prev_rd = mem_rd; prev_wr = mem_wr;
    if (mem_rdy) begin
      logic [1:0] kind;
      logic [17:0] e;
      kind = {mem_rd, mem_rd ? pc_ld : pc_oe};
      if (q.size() == 0) chk(0, "R2/R3 unexpected step", int'({kind, mem_addr}), -1);
      else begin
        e = q.pop_front();
        chk({kind, mem_addr} == e, e[15:0] >= 8 ? "R3" : "R2", int'({kind, mem_addr}), int'(e));
        chk(psw_oe == (e[17:16] == 0) && pc_oe == (e[17:16] == 1) &&
            psw_ld == (e[17:16] == 2) && pc_ld == (e[17:16] == 3) && (mem_wr != mem_rd),
            "R10", int'({psw_oe, pc_oe, psw_ld, pc_ld}), int'(e[17:16]));
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 200 && (busy || q.size() != 0); i++) @(negedge clk);
    #2;
    chk(!busy && q.size() == 0, "R7 swap finished", q.size(), 0);
  endtask

  initial begin
    fork begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end join_none

    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !mem_rd && !mem_wr && !psw_oe && !pc_oe && !psw_ld && !pc_ld && mem_addr == 0,
        "R1", int'({busy, mem_rd, mem_wr, psw_oe, pc_oe}), 0);
    rst_n = 1;

    // R2 and R7: program check, memory ready each cycle
    lat = 0;
    push_swap(16'd0);
    @(negedge clk); chk_req = 1;
    @(negedge clk); chk_req = 0;
    #2 chk(busy, "R7 rise", busy, 1);
    begin
      int n = 0;
      for (int i = 0; i < 20 && busy; i++) begin n++; @(negedge clk); #2; end
      chk(n == 4, "R7 length", n, 4);
    end
    wait_idle();

    // R3: timer at boundary, memory waits two cycles
    lat = 2;
    push_swap(16'd8);
    @(negedge clk); tmr_req = 1; at_boundary = 1;
    @(negedge clk); at_boundary = 0; tmr_req = 0;
    wait_idle();

    // R4: timer without boundary is ignored
    @(negedge clk); tmr_req = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #2;
      chk(!busy && !mem_rd && !mem_wr, "R4", int'({busy, mem_rd, mem_wr}), 0);
    end
    tmr_req = 0;

    // R5: check and timer in the same cycle
    lat = 1;
    push_swap(16'd0); push_swap(16'd8);
    @(negedge clk); chk_req = 1; tmr_req = 1; at_boundary = 1;
    @(negedge clk); chk_req = 0;
    for (int i = 0; i < 100 && q.size() > 4; i++) @(negedge clk);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    tmr_req = 0; at_boundary = 0;
    wait_idle();

    // R9: check pulse during a timer swap
    lat = 3;
    push_swap(16'd8); push_swap(16'd0);
    @(negedge clk); tmr_req = 1; at_boundary = 1;
    @(negedge clk); tmr_req = 0; at_boundary = 0;
    repeat (3) @(negedge clk);
    chk_req = 1;
    @(negedge clk); chk_req = 0;
    wait_idle();
    chk(q.size() == 0, "R9 queue drained", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule